// File: doc/BRIEF.md
# Multi-Mode 32-bit General-Purpose Timer

This block holds a small bank of identical 32-bit timers. Each has one pin, which it drives in waveform generation mode and samples in the other two modes. A timer can produce a pulse train with a programmable period and high time. It can measure the active time and the repeat time of an incoming pulse train. It can also act as a watchdog on an external event: the event must keep arriving before a programmed number of cycles has elapsed.

Each timer has its own 6-bit mode word, a period register and a width register, all written through one shared write port. The running count and the active period and width values are visible on output ports. A shared enable word, one bit per timer, starts and stops each timer without affecting the others. A one-cycle interrupt pulse marks each period boundary in generation mode, each completed measurement in capture mode, and each timeout in watchdog mode. The pin input passes through a two-flop synchronizer before any edge is detected, so it may be fully asynchronous to the clock.

Period and width writes go to a holding copy. That copy moves into the active registers at the next period boundary, and on every clock while the timer is disabled. A running waveform therefore never mixes an old period with a new width.

Top module: `gp_timer`

## Requirements
- R1: After reset every count, period, width and mode word reads zero, no pin is driven and no interrupt is asserted.
- R2: Each bit of `en_i` controls one timer alone. While its bit is low, a timer holds its count at 0, releases its pin, and copies the held period and width into the active registers on every clock.
- R3: Write addresses are 0 for the mode word, 1 for the period and 2 for the width. Mode word fields are: bits [1:0] mode (00 idle, 01 generate, 10 capture, 11 watchdog), bit 2 polarity (1 = active high), bit 3 interrupt enable, bit 4 watchdog both-edge select, bit 5 spare. In generation mode the count runs 1, 2, … P and then returns to 1, where P is the active period; a period of 0 behaves as 1.
- R4: In generation mode the pin is driven (`pin_oe` high) and is at its active level exactly while 1 ≤ count ≤ active width. It is at the opposite level otherwise. The active level follows the polarity bit.
- R5: In generation mode a period or width write leaves the active values, and the `per_o`/`wid_o` readback, unchanged until the count next wraps to 1.
- R6: In capture mode the first leading edge (the change to the active level) arms the timer. After that, each trailing edge latches the count into the width and each leading edge latches the count into the period. A pulse that is active for H cycles and inactive for L cycles reads back width H and period H+L.
- R7: In watchdog mode each selected edge reloads the count to 0. Without an edge the count rises by one per cycle up to the active period P and then holds there. Reaching P raises one interrupt, so edges spaced G cycles apart give a timeout only when G > P.
- R8: In watchdog mode, with bit 4 clear only leading edges reload the count; with bit 4 set both edges do.
- R9: An interrupt is a one-cycle pulse on `irq_o`, asserted in the cycle after the wrap, capture or timeout event. It is suppressed when the interrupt-enable bit is 0.
- R10: In idle mode (00) an enabled timer keeps its count at 0, drives no pin and raises no interrupt. All six mode word bits, including the spare bit, read back on `cfg_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | N_TMR | Per-timer enable word |
| wr_en | input | 1 | Register write strobe |
| wr_tmr | input | IW | Index of the timer being written |
| wr_addr | input | 2 | Register select: 0 mode, 1 period, 2 width |
| wr_data | input | CW | Write data |
| pin_i | input | N_TMR | Sampled level of each timer pin |
| pin_o | output | N_TMR | Level driven onto each timer pin |
| pin_oe | output | N_TMR | Output enable for each timer pin |
| irq_o | output | N_TMR | One-cycle interrupt pulse per timer |
| cfg_o | output | 6*N_TMR | Mode word readback |
| cnt_o | output | CW*N_TMR | Running count per timer |
| per_o | output | CW*N_TMR | Active period per timer |
| wid_o | output | CW*N_TMR | Active width per timer |

## Verification
The properties assume that a timer's mode is changed only while it is disabled or idle. They also assume the count range is judged only when the active period is nonzero, and that the pin is just a level: what a property sees is always what the synchronizer has already delivered. The stimulus keeps to this. It rewrites the mode, period and width only with the enable bit low, leaves two idle cycles before enabling, and in watchdog sweeps uses periods of at least 3 so that no timeout can happen before the first synchronized edge. It changes the pins only on falling clock edges and holds each level for at least one full cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int CFG_W = 6;

  typedef enum logic [1:0] {
    MD_IDLE = 2'd0,
    MD_GEN  = 2'd1,
    MD_CAPT = 2'd2,
    MD_WDOG = 2'd3
  } tmr_mode_e;

  // bit 5 spare, bit 4 both edges, bit 3 irq enable, bit 2 polarity, [1:0] mode
  typedef struct packed {
    logic      spare;
    logic      both;
    logic      ien;
    logic      pol;
    tmr_mode_e mode;
  } tmr_cfg_t;

  typedef enum logic [1:0] {
    RA_CFG  = 2'd0,
    RA_PER  = 2'd1,
    RA_WID  = 2'd2,
    RA_RSVD = 2'd3
  } tmr_addr_e;

endpackage

// File: rtl/tmr_insync.sv
module tmr_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int TOP = STAGES;

  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [TOP:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[TOP-1:0], d_i};
  end

  assign rise_o = sh[TOP-1] & ~sh[TOP];
  assign fall_o = ~sh[TOP-1] & sh[TOP];
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CW   = 32,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          wr_cfg_i,
  input  logic          wr_per_i,
  input  logic          wr_wid_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          pin_i,
  output logic          pin_o,
  output logic          pin_oe_o,
  output logic          irq_o,
  output logic          evt_o,
  output logic          edge_o,
  output tmr_cfg_t      cfg_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] per_o,
  output logic [CW-1:0] wid_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] c);
    return (c == '1) ? c : c + ONE;
  endfunction

  function automatic logic gen_wrap(input logic [CW-1:0] c, input logic [CW-1:0] p);
    return c >= p;
  endfunction

  function automatic logic gen_level(input logic [CW-1:0] c, input logic [CW-1:0] w,
                                     input logic pol);
    logic act;
    act = (c != '0) && (c <= w);
    return pol ? act : ~act;
  endfunction

  tmr_cfg_t      cfg_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] per_sh, wid_sh;
  logic [CW-1:0] per_q, per_d, wid_q, wid_d;
  logic          armed_q, armed_d;
  logic          evt, irq_q;
  logic          rise, fall, lead, trail, wd_edge;

  tmr_insync #(.STAGES(SYNC)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign lead    = cfg_q.pol ? rise : fall;
  assign trail   = cfg_q.pol ? fall : rise;
  assign wd_edge = cfg_q.both ? (rise | fall) : lead;

  always_comb begin
    cnt_d   = cnt_q;
    per_d   = per_q;
    wid_d   = wid_q;
    armed_d = armed_q;
    evt     = 1'b0;
    if (!en_i) begin
      cnt_d   = '0;
      per_d   = per_sh;
      wid_d   = wid_sh;
      armed_d = 1'b0;
    end else begin
      unique case (cfg_q.mode)
        MD_IDLE: begin
          cnt_d   = '0;
          per_d   = per_sh;
          wid_d   = wid_sh;
          armed_d = 1'b0;
        end
        MD_GEN: begin
          if (gen_wrap(cnt_q, per_q)) begin
            cnt_d = ONE;
            per_d = per_sh;
            wid_d = wid_sh;
            evt   = (cnt_q != '0);
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        MD_CAPT: begin
          cnt_d = sat_inc(cnt_q);
          if (lead) begin
            cnt_d   = ONE;
            armed_d = 1'b1;
            if (armed_q) begin
              per_d = cnt_q;
              evt   = 1'b1;
            end
          end
          if (trail && armed_q) wid_d = cnt_q;
        end
        MD_WDOG: begin
          if (wd_edge) begin
            cnt_d = '0;
            per_d = per_sh;
            wid_d = wid_sh;
          end else if (cnt_q < per_q) begin
            cnt_d = cnt_q + ONE;
            if ((cnt_q + ONE) == per_q) begin
              evt   = 1'b1;
              per_d = per_sh;
              wid_d = wid_sh;
            end
          end
        end
        default: cnt_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      per_sh  <= '0;
      wid_sh  <= '0;
      per_q   <= '0;
      wid_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_cfg_i) cfg_q  <= tmr_cfg_t'(wr_data_i[CFG_W-1:0]);
      if (wr_per_i) per_sh <= wr_data_i;
      if (wr_wid_i) wid_sh <= wr_data_i;
      per_q   <= per_d;
      wid_q   <= wid_d;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      irq_q   <= en_i & cfg_q.ien & evt;
    end
  end

  assign pin_o    = gen_level(cnt_q, wid_q, cfg_q.pol);
  assign pin_oe_o = en_i && (cfg_q.mode == MD_GEN);
  assign irq_o    = irq_q;
  assign evt_o    = evt;
  assign edge_o   = (cfg_q.mode == MD_WDOG) ? wd_edge : lead;
  assign cfg_o    = cfg_q;
  assign cnt_o    = cnt_q;
  assign per_o    = per_q;
  assign wid_o    = wid_q;
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import tmr_pkg::*;
#(
  parameter int N_TMR = 2,
  parameter int CW    = 32,
  parameter int SYNC  = 2,
  localparam int IW   = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_TMR-1:0]    en_i,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_tmr,
  input  logic [1:0]          wr_addr,
  input  logic [CW-1:0]       wr_data,
  input  logic [N_TMR-1:0]    pin_i,
  output logic [N_TMR-1:0]    pin_o,
  output logic [N_TMR-1:0]    pin_oe,
  output logic [N_TMR-1:0]    irq_o,
  output logic [N_TMR*6-1:0]  cfg_o,
  output logic [N_TMR*CW-1:0] cnt_o,
  output logic [N_TMR*CW-1:0] per_o,
  output logic [N_TMR*CW-1:0] wid_o
);
  // internal events brought out for the bound checker
  logic [N_TMR-1:0] evt_w;
  logic [N_TMR-1:0] edge_w;

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    logic     hit;
    tmr_cfg_t cfg_w;
    assign hit = wr_en && (wr_tmr == IW'(i));

    tmr_core #(.CW(CW), .SYNC(SYNC)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (en_i[i]),
      .wr_cfg_i  (hit && (wr_addr == RA_CFG)),
      .wr_per_i  (hit && (wr_addr == RA_PER)),
      .wr_wid_i  (hit && (wr_addr == RA_WID)),
      .wr_data_i (wr_data),
      .pin_i     (pin_i[i]),
      .pin_o     (pin_o[i]),
      .pin_oe_o  (pin_oe[i]),
      .irq_o     (irq_o[i]),
      .evt_o     (evt_w[i]),
      .edge_o    (edge_w[i]),
      .cfg_o     (cfg_w),
      .cnt_o     (cnt_o[i*CW +: CW]),
      .per_o     (per_o[i*CW +: CW]),
      .wid_o     (wid_o[i*CW +: CW])
    );
    assign cfg_o[i*CFG_W +: CFG_W] = cfg_w;
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int N_TMR = 2,
  parameter int CW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_TMR-1:0]    en_i,
  input logic [N_TMR-1:0]    pin_o,
  input logic [N_TMR-1:0]    pin_oe,
  input logic [N_TMR-1:0]    irq_o,
  input logic [N_TMR*6-1:0]  cfg_o,
  input logic [N_TMR*CW-1:0] cnt_o,
  input logic [N_TMR*CW-1:0] per_o,
  input logic [N_TMR*CW-1:0] wid_o,
  input logic [N_TMR-1:0]    evt_w,
  input logic [N_TMR-1:0]    edge_w
);
  for (genvar i = 0; i < N_TMR; i++) begin : g_chk
    tmr_cfg_t      f;
    logic [CW-1:0] c, p, w;
    assign f = tmr_cfg_t'(cfg_o[i*CFG_W +: CFG_W]);
    assign c = cnt_o[i*CW +: CW];
    assign p = per_o[i*CW +: CW];
    assign w = wid_o[i*CW +: CW];

    // R2: a disabled timer is at zero one cycle later
    a_r2_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i[i] |=> (c == '0));

    // R3: a generating timer stays within 1..period
    a_r3_gen_range: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i[i] && f.mode == MD_GEN) |=> (c != '0) && ((p == '0) || (c <= p)));

    // R4: pin at active level while inside the width window
    a_r4_gen_level: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe[i] && (c != '0) && (c <= w)) |-> (pin_o[i] == f.pol));

    // R6: a capture event stores the count as the period
    a_r6_capt_period: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i[i] && f.mode == MD_CAPT && evt_w[i]) |=> (p == $past(c)));

    // R7: an expired watchdog holds its count until an edge
    a_r7_wd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i[i] && f.mode == MD_WDOG && !edge_w[i] && (c >= p)) |=> (c == $past(c)));

    // R9: no interrupt without the enable bit
    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !f.ien |=> !irq_o[i]);

    // R9: an enabled event produces an interrupt the next cycle
    a_r9_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i[i] && f.ien && evt_w[i]) |=> irq_o[i]);
  end
endmodule

bind gp_timer tmr_chk #(.N_TMR(N_TMR), .CW(CW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en_i   (en_i),
  .pin_o  (pin_o),
  .pin_oe (pin_oe),
  .irq_o  (irq_o),
  .cfg_o  (cfg_o),
  .cnt_o  (cnt_o),
  .per_o  (per_o),
  .wid_o  (wid_o),
  .evt_w  (evt_w),
  .edge_w (edge_w)
);

// File: tb/sim_gp_timer.sv
`timescale 1ns/1ps
module sim_gp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  en = '0;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_tmr = '0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  pin_i = '0;
  logic [1:0]  pin_o, pin_oe, irq_o;
  logic [11:0] cfg_o;
  logic [63:0] cnt_o, per_o, wid_o;

  always #2.5 clk = ~clk;

  gp_timer u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .wr_en(wr_en), .wr_tmr(wr_tmr),
    .wr_addr(wr_addr), .wr_data(wr_data), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe(pin_oe), .irq_o(irq_o), .cfg_o(cfg_o), .cnt_o(cnt_o),
    .per_o(per_o), .wid_o(wid_o)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // generation-mode model state for timer 0
  int m_cnt, m_per, m_wid, m_sp, m_sw;
  bit m_pol, m_ien;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] mkcfg(input int mode, input bit pol, input bit ien,
                                       input bit both);
    return {1'b0, both, ien, pol, 2'(mode)};
  endfunction

  task automatic wr(input int t, input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_tmr = 1'(t); wr_addr = 2'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup0(input logic [5:0] cfg, input int p, input int w);
    en[0] = 1'b0;
    wr(0, 0, 32'(cfg));
    wr(0, 1, 32'(p));
    wr(0, 2, 32'(w));
    repeat (2) @(negedge clk);
  endtask

  // one clock of timer 0 in generation mode, with an optional register write
  task automatic pcycle(input bit we, input int a, input int d);
    bit ei;
    bit act;
    wr_en = we; wr_tmr = 1'b0; wr_addr = 2'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
    ei = 1'b0;
    if (m_cnt >= m_per) begin
      ei = (m_cnt != 0) && m_ien;
      m_cnt = 1; m_per = m_sp; m_wid = m_sw;
    end else begin
      m_cnt++;
    end
    if (we && a == 1) m_sp = d;
    if (we && a == 2) m_sw = d;
    act = (m_cnt != 0) && (m_cnt <= m_wid);
    chk("R3 gen count", cnt_o[31:0], m_cnt);
    chk("R4 gen pin level", pin_o[0], m_pol ? act : !act);
    chk("R4 gen pin drive", pin_oe[0], 1);
    chk("R9 gen irq", irq_o[0], ei);
    chk("R5 period readback", per_o[31:0], m_per);
    chk("R5 width readback", wid_o[31:0], m_wid);
    chk("R2 other timer idle", cnt_o[63:32], 0);
  endtask

  task automatic gen_start(input bit pol, input bit ien, input int p, input int w);
    setup0(mkcfg(1, pol, ien, 1'b0), p, w);
    chk("R2 shadow copied while disabled", per_o[31:0], p);
    m_cnt = 0; m_per = p; m_wid = w; m_sp = p; m_sw = w; m_pol = pol; m_ien = ien;
    en[0] = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset count", cnt_o, 0);
    chk("R1 reset period", per_o, 0);
    chk("R1 reset width", wid_o, 0);
    chk("R1 reset cfg", cfg_o, 0);
    chk("R1 reset oe", pin_oe, 0);
    chk("R1 reset irq", irq_o, 0);

    // R3 R4 R9 generation sweep
    for (int pol = 0; pol < 2; pol++)
      for (int p = 1; p <= 6; p++)
        for (int w = 0; w <= 7; w++) begin
          gen_start(pol[0], 1'b1, p, w);
          repeat (2 * p + 4) pcycle(1'b0, 0, 0);
          en[0] = 1'b0;
          @(negedge clk);
        end

    // R5 deferred period/width update
    gen_start(1'b1, 1'b1, 4, 2);
    for (int k = 0; k < 10 && m_cnt != 2; k++) pcycle(1'b0, 0, 0);
    pcycle(1'b1, 1, 6);
    pcycle(1'b1, 2, 5);
    repeat (16) pcycle(1'b0, 0, 0);
    en[0] = 1'b0;
    @(negedge clk);

    // R9 interrupt gating
    gen_start(1'b0, 1'b0, 2, 1);
    repeat (8) pcycle(1'b0, 0, 0);
    en[0] = 1'b0;
    @(negedge clk);

    // R6 capture sweep
    for (int pol = 0; pol < 2; pol++)
      for (int h = 1; h <= 5; h++)
        for (int l = 1; l <= 5; l++) begin
          int nirq;
          pin_i[0] = ~pol[0];
          setup0(mkcfg(2, pol[0], 1'b1, 1'b0), 0, 0);
          en[0] = 1'b1;
          nirq = 0;
          for (int k = 0; k < 3; k++) begin
            repeat (h) begin pin_i[0] = pol[0];  @(negedge clk); nirq += irq_o[0]; end
            repeat (l) begin pin_i[0] = ~pol[0]; @(negedge clk); nirq += irq_o[0]; end
          end
          repeat (6) begin @(negedge clk); nirq += irq_o[0]; end
          chk("R6 captured width", wid_o[31:0], h);
          chk("R6 captured period", per_o[31:0], h + l);
          chk("R6 R9 capture irq count", nirq, 2);
          en[0] = 1'b0;
          @(negedge clk);
        end

    // R7 R8 watchdog sweep: square wave with half period g, three full cycles
    for (int both = 0; both < 2; both++)
      for (int pol = 0; pol < 2; pol++)
        for (int p = 3; p <= 6; p++)
          for (int g = 1; g <= 5; g++) begin
            int nirq;
            int exp_irq;
            pin_i[0] = ~pol[0];
            setup0(mkcfg(3, pol[0], 1'b1, both[0]), p, 0);
            en[0] = 1'b1;
            nirq = 0;
            for (int k = 0; k < 3; k++) begin
              repeat (g) begin pin_i[0] = pol[0];  @(negedge clk); nirq += irq_o[0]; end
              repeat (g) begin pin_i[0] = ~pol[0]; @(negedge clk); nirq += irq_o[0]; end
            end
            repeat (p + 6) begin @(negedge clk); nirq += irq_o[0]; end
            if (both != 0) exp_irq = ((g > p) ? 5 : 0) + 1;
            else           exp_irq = ((2 * g > p) ? 2 : 0) + 1;
            chk(both != 0 ? "R8 both-edge timeouts" : "R7 leading-edge timeouts",
                nirq, exp_irq);
            chk("R7 count holds at period", cnt_o[31:0], p);
            en[0] = 1'b0;
            @(negedge clk);
          end

    // R10 idle mode and full cfg readback
    setup0(mkcfg(0, 1'b1, 1'b1, 1'b0) | 6'b100000, 3, 1);
    chk("R10 cfg readback", cfg_o[5:0], 6'b101100);
    en[0] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R10 idle count", cnt_o[31:0], 0);
      chk("R10 idle oe", pin_oe[0], 0);
      chk("R10 idle irq", irq_o[0], 0);
    end
    en[0] = 1'b0;

    // R2 second timer runs alone
    wr(1, 0, 32'(mkcfg(1, 1'b1, 1'b1, 1'b0)));
    wr(1, 1, 3);
    wr(1, 2, 1);
    repeat (2) @(negedge clk);
    en = 2'b10;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk("R2 timer1 count", cnt_o[63:32], ((k - 1) % 3) + 1);
      chk("R2 timer0 untouched", cnt_o[31:0], 0);
      chk("R2 timer0 released", pin_oe[0], 0);
    end
    en = 2'b00;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule